// File: doc/BRIEF.md
# Microcontroller Internal Reset Controller

This block gathers every reset cause that arises inside a small 8-bit microcontroller and turns them into one enable for the pulldown transistor on the external reset pin. It watches the CPU opcode-fetch address and flags fetches from the I/O page or from the two unimplemented holes of the memory map. It traps execution of a STOP instruction when a mask option forbids stop mode. It runs a free-running watchdog that software restarts by writing a zero into bit 0 of a byte it shares with the high half of an unused interrupt vector. It also holds the chip in reset while a low-voltage comparator reports a sagging supply, and for a fixed power-on delay after the supply recovers.

Fetch, STOP and watchdog events each give a pulldown pulse of fixed minimum length. The low-voltage source keeps the pulldown on for as long as the supply stays low, plus the delay. Each cause leaves a sticky flag that a read of the status register clears. The watchdog restarts from zero whenever the pulldown is active, so a fresh count begins after every reset.

Top module: `rstctl_top`

## Requirements
- R1: An opcode fetch (`fetch_valid`=1) from $01C0..$023F or $0340..$0CFF asserts `rst_pull_en` after the next clock edge and sets `stat_flags[0]`.
- R2: An opcode fetch from $0000..$003F does the same as R1; a data read or write (`bus_rd`/`bus_wr`) to that range, with no fetch, leaves `rst_pull_en` low and `stat_flags` unchanged.
- R3: Fetches from $0040, $01BF, $0240, $033F and $0D00 cause no reset and set no flag.
- R4: `stop_exec` with `stop_disable`=1 asserts the pulldown after the next edge and sets `stat_flags[1]`; with `stop_disable`=0 it has no effect.
- R5: With no service write, the watchdog expires 2^WDOG_W clock edges after it was last cleared. Expiry asserts the pulldown and sets `stat_flags[2]`.
- R6: A write to $3FF0 with data bit 0 = 0 clears the watchdog counter. A write of bit 0 = 1, or a write to any other address, leaves the counter unchanged.
- R7: A read of $3FF0 returns the parameter byte `USER_VEC_HI` on `bus_rdata` and leaves the watchdog counter unchanged.
- R8: The watchdog counter holds at zero while `rst_pull_en` is high, so it restarts from zero after any reset.
- R9: While `lv_below`=1 the pulldown stays on and `stat_flags[3]` is set. After `lv_below` returns to 0, the pulldown releases on the POR_DLY-th clock edge.
- R10: If `lv_below` pulses high during the release delay, the delay starts over from the new rising supply.
- R11: A one-cycle fetch, STOP or watchdog trigger holds `rst_pull_en` high for exactly PULSE_MIN cycles.
- R12: `stat_flags` bits are sticky. A `stat_rd` cycle clears them all, but a cause that fires in the same cycle still sets its bit. Bit map: 0 illegal fetch, 1 STOP trap, 2 watchdog, 3 low voltage.
- R13: After `rst_n` is released, the pulldown stays on for POR_DLY clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| fetch_valid | input | 1 | Opcode-fetch strobe from the CPU |
| fetch_addr | input | 16 | Address of the opcode fetch |
| stop_exec | input | 1 | CPU is executing a STOP instruction |
| stop_disable | input | 1 | Mask option: stop mode forbidden |
| bus_wr | input | 1 | Data write strobe |
| bus_rd | input | 1 | Data read strobe |
| bus_addr | input | 16 | Data access address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the service location, zero elsewhere |
| lv_below | input | 1 | Comparator: supply under threshold |
| stat_rd | input | 1 | Read of the status register (clears flags) |
| rst_pull_en | output | 1 | Enable for the reset pin pulldown |
| stat_flags | output | 4 | Sticky reset-cause flags |

## Verification
The bench builds the block with a 6-bit watchdog, a 16-cycle power-on delay and a 4-cycle pulse. With these values, full watchdog expiry after 64 edges, and the change in that count caused by ignored and accepted service writes, can be measured cycle by cycle. Complete and restarted low-voltage release delays also fit within a short run. Each address-range boundary is probed on both sides, and the exact pulse length is counted for each trigger source.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int ADDR_W = 16;
    typedef logic [ADDR_W-1:0] addr_t;

    // Forbidden opcode-fetch windows: I/O page and two unimplemented holes
    localparam int NUM_HOLES = 3;

    localparam addr_t SVC_ADDR = 16'h3FF0;

    // Cause flag positions
    localparam int FLG_FETCH = 0;
    localparam int FLG_STOP  = 1;
    localparam int FLG_WDOG  = 2;
    localparam int FLG_LOWV  = 3;
    localparam int NUM_FLG   = 4;
    typedef logic [NUM_FLG-1:0] flags_t;

    function automatic addr_t hole_lo(input int idx);
        case (idx)
            0:       return 16'h0000;
            1:       return 16'h01C0;
            default: return 16'h0340;
        endcase
    endfunction

    function automatic addr_t hole_hi(input int idx);
        case (idx)
            0:       return 16'h003F;
            1:       return 16'h023F;
            default: return 16'h0CFF;
        endcase
    endfunction

endpackage

// File: rtl/rstctl_fetch_chk.sv
module rstctl_fetch_chk
    import rstctl_pkg::*;
(
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              bad_fetch
);

    logic [NUM_HOLES-1:0] hit;

    for (genvar g = 0; g < NUM_HOLES; g++) begin : g_hole
        localparam addr_t LO = hole_lo(g);
        localparam addr_t HI = hole_hi(g);
        if (LO == '0) begin : g_base
            // window starts at zero: only the upper bound matters
            assign hit[g] = (fetch_addr <= HI);
        end else begin : g_mid
            assign hit[g] = (fetch_addr >= LO) && (fetch_addr <= HI);
        end
    end

    assign bad_fetch = fetch_valid && (|hit);

endmodule

// File: rtl/rstctl_wdog.sv
module rstctl_wdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             kick,
    output logic             expire,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wd_state_t;

    wd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold || kick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire = !hold && (st_q.cnt == '1);
    assign count  = st_q.cnt;

endmodule

// File: rtl/rstctl_lowv.sv
module rstctl_lowv #(
    parameter int DLY = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lv_below,
    output logic active
);

    localparam int DLY_W = $clog2(DLY + 1);
    localparam logic [DLY_W-1:0] LAST = DLY_W'(DLY - 1);

    typedef struct packed {
        logic             hold;
        logic [DLY_W-1:0] dly;
    } lv_state_t;

    lv_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lv_below) begin
            st_d.hold = 1'b1;
            st_d.dly  = '0;
        end else if (st_q.hold) begin
            if (st_q.dly == LAST) begin
                st_d.hold = 1'b0;
                st_d.dly  = '0;
            end else begin
                st_d.dly = st_q.dly + DLY_W'(1);
            end
        end
    end

    // power-up behaves like a supply that has just risen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold <= 1'b1;
            st_q.dly  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.hold;

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int                WDOG_W      = 16,
    parameter int                POR_DLY     = 4096,
    parameter int                PULSE_MIN   = 4,
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] USER_VEC_HI = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              stop_exec,
    input  logic              stop_disable,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lv_below,
    input  logic              stat_rd,
    output logic              rst_pull_en,
    output logic [NUM_FLG-1:0] stat_flags
);

    localparam int ST_W = $clog2(PULSE_MIN + 1);

    typedef struct packed {
        logic [ST_W-1:0] stretch;
        flags_t          flg;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              bad_fetch;
    logic              stop_trap;
    logic              wd_expire;
    logic              wd_kick;
    logic [WDOG_W-1:0] wd_cnt;
    logic              lv_active;
    logic              trig;
    logic              svc_hit;
    logic              unused_wdata_hi;
    flags_t            set_vec;

    rstctl_fetch_chk u_fetch (
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .bad_fetch   (bad_fetch)
    );

    rstctl_wdog #(.CNT_W(WDOG_W)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (rst_pull_en),
        .kick   (wd_kick),
        .expire (wd_expire),
        .count  (wd_cnt)
    );

    rstctl_lowv #(.DLY(POR_DLY)) u_lowv (
        .clk      (clk),
        .rst_n    (rst_n),
        .lv_below (lv_below),
        .active   (lv_active)
    );

    assign svc_hit         = (bus_addr == SVC_ADDR);
    assign wd_kick         = bus_wr && svc_hit && !bus_wdata[0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:1];
    assign bus_rdata       = (bus_rd && svc_hit) ? USER_VEC_HI : '0;
    assign stop_trap       = stop_exec && stop_disable;
    assign trig            = bad_fetch || stop_trap || wd_expire;

    always_comb begin
        set_vec            = '0;
        set_vec[FLG_FETCH] = bad_fetch;
        set_vec[FLG_STOP]  = stop_trap;
        set_vec[FLG_WDOG]  = wd_expire;
        set_vec[FLG_LOWV]  = lv_below;

        st_d = st_q;
        if (trig) begin
            st_d.stretch = ST_W'(PULSE_MIN);
        end else if (st_q.stretch != '0) begin
            st_d.stretch = st_q.stretch - ST_W'(1);
        end
        // a cause in the clearing cycle is kept
        st_d.flg = (stat_rd ? '0 : st_q.flg) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_pull_en = (st_q.stretch != '0) || lv_active;
    assign stat_flags  = st_q.flg;

endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
    parameter int WDOG_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic [15:0]       fetch_addr,
    input logic              stop_exec,
    input logic              stop_disable,
    input logic              bus_wr,
    input logic [15:0]       bus_addr,
    input logic              wbit0,
    input logic              lv_below,
    input logic              stat_rd,
    input logic              rst_pull_en,
    input logic [3:0]        stat_flags,
    input logic [WDOG_W-1:0] wd_cnt
);

    logic io_fetch, hole_fetch, kick_seen;
    assign io_fetch   = fetch_valid && (fetch_addr <= 16'h003F);
    assign hole_fetch = fetch_valid &&
                        (((fetch_addr >= 16'h01C0) && (fetch_addr <= 16'h023F)) ||
                         ((fetch_addr >= 16'h0340) && (fetch_addr <= 16'h0CFF)));
    assign kick_seen  = bus_wr && (bus_addr == 16'h3FF0) && !wbit0;

    AST_HOLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        hole_fetch |=> (rst_pull_en && stat_flags[0])); // R1
    AST_IO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        io_fetch |=> (rst_pull_en && stat_flags[0])); // R2
    AST_STOP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_exec && stop_disable) |=> (rst_pull_en && stat_flags[1])); // R4
    AST_WDOG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_pull_en && !kick_seen) |=> (wd_cnt == WDOG_W'($past(wd_cnt) + 1))); // R5
    AST_SVC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        kick_seen |=> (wd_cnt == '0)); // R6
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pull_en |=> (wd_cnt == '0)); // R8
    AST_LOWV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lv_below |=> (rst_pull_en && stat_flags[3])); // R9
    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pull_en) |=> rst_pull_en); // R11
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((stat_flags | $past(stat_flags)) == stat_flags)); // R12

endmodule

bind rstctl_top rstctl_chk #(.WDOG_W(WDOG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_addr   (fetch_addr),
    .stop_exec    (stop_exec),
    .stop_disable (stop_disable),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .wbit0        (bus_wdata[0]),
    .lv_below     (lv_below),
    .stat_rd      (stat_rd),
    .rst_pull_en  (rst_pull_en),
    .stat_flags   (stat_flags),
    .wd_cnt       (wd_cnt)
);

// File: tb/rstctl_top_test.sv
module rstctl_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_W  = 6;
    localparam int WD_SPAN = 1 << WD_W;
    localparam int POR   = 16;
    localparam int PULSE = 4;
    localparam logic [7:0] UBYTE = 8'hC3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        stop_exec = 1'b0;
    logic        stop_disable = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        lv_below = 1'b0;
    logic        stat_rd = 1'b0;
    logic        rst_pull_en;
    logic [3:0]  stat_flags;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstctl_top #(
        .WDOG_W(WD_W), .POR_DLY(POR), .PULSE_MIN(PULSE),
        .DATA_W(8), .USER_VEC_HI(UBYTE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .stop_exec(stop_exec), .stop_disable(stop_disable), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .lv_below(lv_below), .stat_rd(stat_rd),
        .rst_pull_en(rst_pull_en), .stat_flags(stat_flags)
    );

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_release(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_pull_en && n < 5000);
    endtask

    task automatic count_until_pull(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_pull_en && n < 5000);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic kick();
        bus_write(16'h3FF0, 8'h00);
    endtask

    task automatic clr_flags();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        int n;
        chk("R13 pulldown during reset", int'(rst_pull_en), 1);
        chk("R12 flags at reset", int'(stat_flags), 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_release(n);
        chk("R13 power-on hold length", n, POR);
        chk("R12 flags after power-on", int'(stat_flags), 0);
    endtask

    task automatic t_fetch(input string tag, input logic [15:0] a, input bit bad);
        int n;
        kick();
        fetch_valid = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_valid = 1'b0; fetch_addr = '0;
        chk({tag, " pulldown"}, int'(rst_pull_en), int'(bad));
        chk({tag, " fetch flag"}, int'(stat_flags[0]), int'(bad));
        if (bad) begin
            n = 0;
            while (rst_pull_en && n < 100) begin
                n++;
                @(negedge clk);
            end
            chk("R11 fetch pulse length", n, PULSE);
            clr_flags();
            chk("R12 flags cleared", int'(stat_flags), 0);
        end
    endtask

    task automatic t_io_data();
        kick();
        bus_rd = 1'b1; bus_addr = 16'h0010;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = 16'h0020; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
        @(negedge clk);
        chk("R2 data access to I/O pulldown", int'(rst_pull_en), 0);
        chk("R2 data access to I/O flags", int'(stat_flags), 0);
    endtask

    task automatic t_stop();
        int n;
        kick();
        stop_disable = 1'b0; stop_exec = 1'b1;
        @(negedge clk);
        stop_exec = 1'b0;
        @(negedge clk);
        chk("R4 stop allowed pulldown", int'(rst_pull_en), 0);
        chk("R4 stop allowed flags", int'(stat_flags), 0);
        stop_disable = 1'b1; stop_exec = 1'b1;
        @(negedge clk);
        stop_exec = 1'b0;
        chk("R4 stop trapped pulldown", int'(rst_pull_en), 1);
        chk("R4 stop trapped flag", int'(stat_flags), 4'b0010);
        n = 0;
        while (rst_pull_en && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R11 stop pulse length", n, PULSE);
        stop_disable = 1'b0;
        clr_flags();
    endtask

    // starts right after a release: counter is zero there (R8)
    task automatic t_wdog_run(input string tag, input int kind, input int exp_n);
        int n;
        repeat (20) @(negedge clk);
        case (kind)
            0: bus_write(16'h3FF0, 8'h01);
            1: bus_write(16'h3FF1, 8'h00);
            2: begin
                bus_rd = 1'b1; bus_addr = 16'h3FF0;
                #1;
                chk("R7 service location read data", int'(bus_rdata), int'(UBYTE));
                @(negedge clk);
                bus_rd = 1'b0; bus_addr = '0;
            end
            default: bus_write(16'h3FF0, 8'hFE);
        endcase
        count_until_pull(n);
        chk(tag, n, exp_n);
        chk("R5 watchdog flag", int'(stat_flags), 4'b0100);
        clr_flags();
        wait_release(n);
    endtask

    task automatic t_wdog();
        int n;
        // fresh reset, then free run
        fetch_valid = 1'b1; fetch_addr = 16'h0000;
        @(negedge clk);
        fetch_valid = 1'b0;
        clr_flags();
        wait_release(n);
        count_until_pull(n);
        chk("R5 R8 free-running expiry", n, WD_SPAN);
        chk("R5 watchdog flag", int'(stat_flags), 4'b0100);
        clr_flags();
        wait_release(n);
        t_wdog_run("R6 bit0=1 write ignored", 0, WD_SPAN - 21);
        t_wdog_run("R6 other address ignored", 1, WD_SPAN - 21);
        t_wdog_run("R7 read leaves counter", 2, WD_SPAN - 21);
        t_wdog_run("R6 bit0=0 write clears", 3, WD_SPAN);
    endtask

    task automatic t_lowv();
        int n;
        kick();
        lv_below = 1'b1;
        @(negedge clk);
        chk("R9 low supply pulldown", int'(rst_pull_en), 1);
        chk("R9 low supply flag", int'(stat_flags[3]), 1);
        repeat (3) @(negedge clk);
        lv_below = 1'b0;
        wait_release(n);
        chk("R9 release delay", n, POR);
        lv_below = 1'b1;
        @(negedge clk);
        lv_below = 1'b0;
        repeat (8) @(negedge clk);
        chk("R10 still held mid-delay", int'(rst_pull_en), 1);
        lv_below = 1'b1;
        @(negedge clk);
        lv_below = 1'b0;
        wait_release(n);
        chk("R10 restarted delay", n, POR);
    endtask

    task automatic t_flags();
        int n;
        // low-voltage flag still set from before
        chk("R12 sticky low-voltage flag", int'(stat_flags), 4'b1000);
        kick();
        stat_rd = 1'b1; fetch_valid = 1'b1; fetch_addr = 16'h0200;
        @(negedge clk);
        stat_rd = 1'b0; fetch_valid = 1'b0; fetch_addr = '0;
        chk("R12 set wins over clear", int'(stat_flags), 4'b0001);
        wait_release(n);
        clr_flags();
        chk("R12 cleared by read", int'(stat_flags), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_fetch("R1 fetch 01C0", 16'h01C0, 1'b1);
        t_fetch("R1 fetch 023F", 16'h023F, 1'b1);
        t_fetch("R1 fetch 0340", 16'h0340, 1'b1);
        t_fetch("R1 fetch 0CFF", 16'h0CFF, 1'b1);
        t_fetch("R2 fetch 0000", 16'h0000, 1'b1);
        t_fetch("R2 fetch 003F", 16'h003F, 1'b1);
        t_fetch("R3 fetch 0040", 16'h0040, 1'b0);
        t_fetch("R3 fetch 01BF", 16'h01BF, 1'b0);
        t_fetch("R3 fetch 0240", 16'h0240, 1'b0);
        t_fetch("R3 fetch 033F", 16'h033F, 1'b0);
        t_fetch("R3 fetch 0D00", 16'h0D00, 1'b0);
        t_io_data();
        t_stop();
        t_wdog();
        t_lowv();
        t_flags();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL timeout: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule